// File: doc/BRIEF.md
# Level-Sensitive Three-Clock Scan Register

This block is a short scan register made of level-sensitive storage cells. Each cell holds two latches. The master latch can load from two sources. It is transparent to the cell's functional data input while the capture clock is high. It is transparent to the cell's scan input while the shift-master clock is high. The slave latch is transparent to the master while the shift-slave clock is high. No edge-triggered flop and no select multiplexer choose the source: the clock that pulses decides which input is loaded.

Cells are chained. Each slave output drives the scan input of the next cell, and the slave of the last cell is the chain's scan-out. A test controller outside the block supplies the three clocks, which must never be high together. One shift step is a master-clock pulse followed by a slave-clock pulse. One capture is a capture-clock pulse followed by a slave-clock pulse. A small monitor samples the three clocks on a free-running system clock and raises a sticky flag if two of them are ever high at the same time. A parameter selects whether the master or the slave output drives the downstream logic. There is no streaming data path, so every pin is a plain level.

Top module: `lssd_scan_chain`

## Requirements
- R1: While `rst_n` is low, every master latch, every slave latch and `overlap_err` read 0.
- R2: While `clk_c` is high and `clk_a` is low, each master output `l1_q[i]` follows `sys_d[i]` within the same cycle.
- R3: While `clk_a` is high and `clk_c` is low, master `l1_q[0]` follows `scan_in`, and master `l1_q[i]` follows `l2_q[i-1]` for i > 0.
- R4: While `clk_b` is high, each slave output `l2_q[i]` follows `l1_q[i]`.
- R5: While all three clock inputs are low, changes on `sys_d` and `scan_in` leave `l1_q` and `l2_q` unchanged.
- R6: A shift step (an `clk_a` pulse, then a `clk_b` pulse) moves the slave word up by one position, with `scan_in` entering bit 0. `scan_out` always equals `l2_q[CHAIN_LEN-1]`.
- R7: A capture (a `clk_c` pulse, then a `clk_b` pulse) leaves `sys_d` on `l2_q`.
- R8: `func_q` equals `l2_q` when parameter `TAP` is `TAP_L2`, and equals `l1_q` when `TAP` is `TAP_L1`.
- R9: `overlap_err` goes to 1 at the first `sys_clk` rising edge that samples two or more of `clk_c`, `clk_a`, `clk_b` high. It then stays 1 until reset.
- R10: If `clk_c` and `clk_a` are both high, the master latch takes `sys_d`, not the scan input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running clock for the overlap monitor |
| rst_n | input | 1 | Active-low asynchronous clear |
| clk_c | input | 1 | Capture clock; master loads functional data |
| clk_a | input | 1 | Shift-master clock; master loads scan input |
| clk_b | input | 1 | Shift-slave clock; slave copies master |
| sys_d | input | CHAIN_LEN | Functional data, one bit per cell |
| scan_in | input | 1 | Serial scan input of cell 0 |
| l1_q | output | CHAIN_LEN | Master latch outputs |
| l2_q | output | CHAIN_LEN | Slave latch outputs |
| func_q | output | CHAIN_LEN | Output toward downstream logic, chosen by TAP |
| scan_out | output | 1 | Slave output of the last cell |
| overlap_err | output | 1 | Sticky flag for overlapping clocks |

## Verification
The bench builds a four-cell chain twice on shared inputs, once with each `TAP` value. This lets one run compare both output choices. Four cells keep the word space small, so all 16 capture words are swept. Each captured word is shifted out while a derived 4-bit word is shifted in. Every slave position and every scan-out bit is checked against an arithmetic shift model. The run ends with deliberately overlapped capture and shift-master clocks, which exercises the priority rule and the sticky error flag.

// File: rtl/lssd_pkg.sv
`timescale 1ns/1ps
package lssd_pkg;
  typedef enum logic {TAP_L1 = 1'b0, TAP_L2 = 1'b1} tap_e;
  localparam int unsigned NUM_TEST_CLKS = 3;
endpackage

// File: rtl/lssd_cell.sv
`timescale 1ns/1ps
module lssd_cell (
  input  logic sys_clk,
  input  logic rst_n,
  input  logic clk_c,
  input  logic clk_a,
  input  logic clk_b,
  input  logic d,
  input  logic si,
  output logic l1,
  output logic l2
);
  // master: two-port latch, capture clock has priority
  always_latch begin
    if (!rst_n)     l1 <= 1'b0;
    else if (clk_c) l1 <= d;
    else if (clk_a) l1 <= si;
  end

  // slave: copies master
  always_latch begin
    if (!rst_n)     l2 <= 1'b0;
    else if (clk_b) l2 <= l1;
  end

  logic past_ok;
  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  logic idle;
  assign idle = !clk_c && !clk_a && !clk_b;

  AST_CAPTURE_LOADS: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (clk_c && !clk_b) |-> (l1 == d)); // R2
  AST_SCAN_LOADS: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (clk_a && !clk_c && !clk_b) |-> (l1 == si)); // R3
  AST_SLAVE_COPIES: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (clk_b && !clk_c && !clk_a) |-> (l2 == l1)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (past_ok && idle && $past(idle)) |-> ($stable(l1) && $stable(l2))); // R5
endmodule

// File: rtl/lssd_overlap_mon.sv
`timescale 1ns/1ps
module lssd_overlap_mon (
  input  logic sys_clk,
  input  logic rst_n,
  input  logic clk_c,
  input  logic clk_a,
  input  logic clk_b,
  output logic err
);
  logic [lssd_pkg::NUM_TEST_CLKS-1:0] clk_vec;
  logic clash;
  assign clk_vec = {clk_c, clk_a, clk_b};
  assign clash = ($countones(clk_vec) > 1);

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n)     err <= 1'b0;
    else if (clash) err <= 1'b1;

  AST_ERR_SETS: assert property (@(posedge sys_clk) disable iff (!rst_n)
    clash |=> err); // R9
  AST_ERR_STICKY: assert property (@(posedge sys_clk) disable iff (!rst_n)
    err |=> err); // R9
endmodule

// File: rtl/lssd_scan_chain.sv
`timescale 1ns/1ps
module lssd_scan_chain #(
  parameter int unsigned     CHAIN_LEN = 4,
  parameter lssd_pkg::tap_e  TAP       = lssd_pkg::TAP_L2
) (
  input  logic                 sys_clk,
  input  logic                 rst_n,
  input  logic                 clk_c,
  input  logic                 clk_a,
  input  logic                 clk_b,
  input  logic [CHAIN_LEN-1:0] sys_d,
  input  logic                 scan_in,
  output logic [CHAIN_LEN-1:0] l1_q,
  output logic [CHAIN_LEN-1:0] l2_q,
  output logic [CHAIN_LEN-1:0] func_q,
  output logic                 scan_out,
  output logic                 overlap_err
);
  localparam int unsigned LAST = CHAIN_LEN - 1;

  logic [CHAIN_LEN-1:0] link;

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign link[i] = scan_in;
    end else begin : g_body
      assign link[i] = l2_q[i-1];
    end
    lssd_cell u_cell (
      .sys_clk (sys_clk),
      .rst_n   (rst_n),
      .clk_c   (clk_c),
      .clk_a   (clk_a),
      .clk_b   (clk_b),
      .d       (sys_d[i]),
      .si      (link[i]),
      .l1      (l1_q[i]),
      .l2      (l2_q[i])
    );
  end

  if (TAP == lssd_pkg::TAP_L2) begin : g_tap_l2
    assign func_q = l2_q;
  end else begin : g_tap_l1
    assign func_q = l1_q;
  end

  assign scan_out = l2_q[LAST];

  lssd_overlap_mon u_mon (
    .sys_clk (sys_clk),
    .rst_n   (rst_n),
    .clk_c   (clk_c),
    .clk_a   (clk_a),
    .clk_b   (clk_b),
    .err     (overlap_err)
  );

  AST_RESET_CLEAR: assert property (@(posedge sys_clk)
    !rst_n |-> (l1_q == '0 && l2_q == '0 && !overlap_err)); // R1
  AST_SHIFT_MOVES: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (clk_a && !clk_c && !clk_b) |-> (l1_q[0] == scan_in)); // R6
endmodule

// File: tb/lssd_scan_chain_tb.sv
`timescale 1ns/1ps
module lssd_scan_chain_tb;
  localparam int N = 4;

  logic sys_clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_c = 1'b0, clk_a = 1'b0, clk_b = 1'b0;
  logic [N-1:0] sys_d = '0;
  logic scan_in = 1'b0;
  logic [N-1:0] l1_q, l2_q, func_q, l1b_q, l2b_q, funcb_q;
  logic scan_out, scanb_out, overlap_err, errb;

  int checks = 0;
  int errors = 0;

  always #5 sys_clk = ~sys_clk;

  lssd_scan_chain #(.CHAIN_LEN(N), .TAP(lssd_pkg::TAP_L2)) u_dut (
    .sys_clk(sys_clk), .rst_n(rst_n), .clk_c(clk_c), .clk_a(clk_a), .clk_b(clk_b),
    .sys_d(sys_d), .scan_in(scan_in), .l1_q(l1_q), .l2_q(l2_q), .func_q(func_q),
    .scan_out(scan_out), .overlap_err(overlap_err));

  lssd_scan_chain #(.CHAIN_LEN(N), .TAP(lssd_pkg::TAP_L1)) u_dut_l1 (
    .sys_clk(sys_clk), .rst_n(rst_n), .clk_c(clk_c), .clk_a(clk_a), .clk_b(clk_b),
    .sys_d(sys_d), .scan_in(scan_in), .l1_q(l1b_q), .l2_q(l2b_q), .func_q(funcb_q),
    .scan_out(scanb_out), .overlap_err(errb));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // raise one clock at a falling edge; hold for one period; checks happen mid-pulse
  task automatic raise(input int which);
    @(negedge sys_clk);
    if (which == 0) clk_c = 1'b1;
    else if (which == 1) clk_a = 1'b1;
    else clk_b = 1'b1;
    #1;
  endtask

  task automatic drop_all;
    @(negedge sys_clk);
    clk_c = 1'b0; clk_a = 1'b0; clk_b = 1'b0;
    #1;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [N-1:0] model;
    logic [N-1:0] sword;
    logic [N-1:0] l1_before, l2_before;

    repeat (3) @(negedge sys_clk);
    check("R1 l1 reset", l1_q, 0);
    check("R1 l2 reset", l2_q, 0);
    check("R1 err reset", overlap_err, 0);
    rst_n = 1'b1;

    for (int p = 0; p < 16; p++) begin
      // capture
      sys_d = p[N-1:0];
      raise(0);
      check("R2 l1 follows data", l1_q, p);
      drop_all();
      raise(2);
      check("R4 slave copies", l2_q, p);
      drop_all();
      check("R7 capture on l2", l2_q, p);
      check("R8 func tap l2", func_q, p);
      check("R8 func tap l1", funcb_q, p);

      // hold with all clocks low
      l1_before = l1_q; l2_before = l2_q;
      @(negedge sys_clk);
      sys_d = ~p[N-1:0]; scan_in = ~scan_in;
      repeat (2) @(negedge sys_clk);
      #1;
      check("R5 l1 hold", l1_q, l1_before);
      check("R5 l2 hold", l2_q, l2_before);

      // shift out captured word, shift in derived word
      model = p[N-1:0];
      sword = N'((p * 5 + 3) & 15);
      for (int k = 0; k < N; k++) begin
        check("R6 scan_out bit", scan_out, model[N-1]);
        scan_in = sword[k];
        raise(1);
        check("R3 l1 takes shifted word", l1_q, {model[N-2:0], sword[k]});
        check("R8 tap l1 mid-shift", funcb_q, {model[N-2:0], sword[k]});
        check("R8 tap l2 mid-shift", func_q, model);
        drop_all();
        raise(2);
        model = {model[N-2:0], sword[k]};
        check("R4 slave after shift", l2_q, model);
        drop_all();
      end
      check("R6 shifted-in word", l2_q, {sword[0], sword[1], sword[2], sword[3]});
      check("R9 no error in clean run", overlap_err, 0);
    end

    // overlap of capture and shift-master clocks
    @(negedge sys_clk);
    sys_d = 4'hA; scan_in = 1'b1;
    clk_c = 1'b1; clk_a = 1'b1;
    #1;
    check("R10 data wins over scan", l1_q, 4'hA);
    drop_all();
    check("R9 error set", overlap_err, 1);
    repeat (3) @(negedge sys_clk);
    check("R9 error sticky", overlap_err, 1);
    rst_n = 1'b0;
    @(negedge sys_clk);
    check("R1 error cleared by reset", overlap_err, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge sys_clk);
    finish_run();
  end
endmodule